// File: doc/BRIEF.md
# Priority Interrupt Controller with Cascade Configuration

This block collects eight interrupt lines, picks the most urgent one that is allowed through, raises a single interrupt output toward a processor and, on a one-cycle acknowledge pulse, delivers an 8-bit vector and records the line as in service. Software reaches it through two byte addresses. Address 0 is the command port. Address 1 is the data port, which carries the mask register.

After reset the controller stays silent until a short initialization sequence has been written. A command word with bit 4 set (normally 0x11) starts the sequence. The data-port writes that follow supply, in this order, the vector base, the cascade word and, when requested, a mode word. After that, command words select which register a command-port read returns, or retire a specific in-service level.

The cascade word is only stored and presented as configuration. A `slave_mode` strap decides how it is read: as a map of the lines that have a downstream controller, or as this controller's 3-bit identity.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out` is 0, the mask register reads 0x00 at address 1, and both the request register and the in-service register are 0x00. A command-port read returns the request register.
- R2: A command-port write with bit 4 set starts initialization, and bit 0 of that write says whether a mode word follows. The next data-port writes are taken as the base, then the cascade word, then the mode word if one was requested. `int_out` stays 0 until the last word of the sequence has been written.
- R3: During an acknowledge cycle `int_vector` equals the base plus the level being acknowledged, computed modulo 256.
- R4: When `slave_mode` is 0, `cascade_cfg` holds the full cascade word (0x04 means a downstream controller on line 2). When `slave_mode` is 1, it holds only bits 2:0 of that word, with bits 7:3 zero.
- R5: If bit 1 of the mode word is 1 (auto-EOI), an acknowledge does not set the in-service bit.
- R6: Outside initialization, a data-port write loads the mask register. A mask bit of 1 keeps that line from raising `int_out`, and 0xFF blocks every line.
- R7: Priority is fixed, with line 0 the highest. `int_out` is 1 only when some line is both requested and unmasked, and the best such line ranks above every level currently in service.
- R8: A rising edge on `irq_in[n]` sets request bit n. An acknowledge of level n clears that bit. An input held high does not set the bit again.
- R9: An `int_ack` pulse while `int_out` is 1 sets the in-service bit of the winning level on the clock edge that ends the pulse.
- R10: A command write of 0x60+L (L from 0 to 7) clears in-service bit L and leaves the other in-service bits unchanged.
- R11: A command write of 0x0B makes later command-port reads return the in-service register. A command write of 0x0A switches them back to the request register.
- R12: An `int_ack` while `int_out` is 0 is spurious. It returns base+7 even if line 7 is masked, and it leaves both the request register and the in-service register unchanged.
- R13: When a specific EOI and an acknowledge occur in the same cycle, both take effect. The EOI level is cleared and the acknowledged level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 1 | 0 selects the command port, 1 selects the data/mask port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from `bus_addr`) |
| slave_mode | input | 1 | Strap: 1 means this controller is a downstream controller |
| irq_in | input | 8 | Interrupt request lines (edge-sensitive) |
| int_ack | input | 1 | One-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| int_vector | output | 8 | Vector, valid during the `int_ack` cycle |
| cascade_cfg | output | 8 | Stored cascade configuration |

## Verification
Two functions can land in the same cycle: an acknowledge that sets an in-service bit, and a specific EOI written on the command port that clears one. The bench provokes this by holding level 1 in service, raising line 0, and then asserting `int_ack` together with a 0x61 command write in a single cycle. It judges the result through the in-service register read-back, which must show only bit 0, while the vector sampled in that cycle must be base+0. A second overlap is also exercised: an input that stays high across its own acknowledge, which must not produce a second request.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    localparam int unsigned LINES = 8;
    localparam int unsigned LW    = $clog2(LINES);
    localparam int unsigned DW    = 8;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_RUN
    } init_st_e;

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW-1:0] casc;
        logic          aeoi;
        logic          want_mode;
    } pic_cfg_t;

    localparam logic [2:0] EOI_SPEC_TAG = 3'b011;

    // lowest set index wins; returns LINES-1 when nothing is set
    function automatic logic [LW-1:0] first_set(input logic [LINES-1:0] v);
        logic [LW-1:0] idx;
        idx = LW'(LINES - 1);
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) idx = LW'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    input  logic             slave_mode,
    output pic_cfg_t         cfg,
    output logic             ready,
    output logic [LINES-1:0] mask,
    output logic             rd_isr,
    output logic             eoi_valid,
    output logic [LW-1:0]    eoi_lvl
);

    init_st_e state;
    logic     cmd_wr, dat_wr, init_start, sel_cmd;

    assign cmd_wr     = wr && !addr;
    assign dat_wr     = wr && addr;
    assign init_start = cmd_wr && wdata[4];
    assign sel_cmd    = cmd_wr && (wdata[7:5] == 3'b000) && (wdata[4:3] == 2'b01) && wdata[1];
    assign eoi_valid  = cmd_wr && !wdata[4] && (wdata[7:5] == EOI_SPEC_TAG) && (state == ST_RUN);
    assign eoi_lvl    = wdata[LW-1:0];
    assign ready      = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_UNINIT;
            cfg    <= '0;
            mask   <= '0;
            rd_isr <= 1'b0;
        end else if (init_start) begin
            state         <= ST_BASE;
            cfg.want_mode <= wdata[0];
            cfg.aeoi      <= 1'b0;
        end else if (dat_wr) begin
            case (state)
                ST_BASE: begin
                    cfg.base <= wdata;
                    state    <= ST_CASC;
                end
                ST_CASC: begin
                    cfg.casc <= slave_mode ? {5'b00000, wdata[2:0]} : wdata;
                    state    <= cfg.want_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    cfg.aeoi <= wdata[1];
                    state    <= ST_RUN;
                end
                default: mask <= wdata;
            endcase
        end else if (sel_cmd) begin
            rd_isr <= wdata[0];
        end
    end

    // R2: the base word is always followed by the cascade word
    p_seq_base_casc_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BASE && dat_wr && !init_start) |=> (state == ST_CASC));

    // R6: a data write in run state lands in the mask register
    p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && dat_wr) |=> (mask == $past(wdata)));

endmodule

// File: rtl/pic8_pending.sv
module pic8_pending
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_in,
    input  logic             ack,
    input  logic             grant,
    input  logic [LW-1:0]    grant_lvl,
    input  logic             aeoi,
    input  logic             eoi_valid,
    input  logic [LW-1:0]    eoi_lvl,
    output logic [LINES-1:0] irr,
    output logic [LINES-1:0] isr
);

    logic [LINES-1:0] prev, rise, take, drop;

    assign rise = irq_in & ~prev;
    assign take = (ack && grant) ? (LINES'(1) << grant_lvl) : '0;
    assign drop = eoi_valid ? (LINES'(1) << eoi_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            irr  <= '0;
            isr  <= '0;
        end else begin
            prev <= irq_in;
            irr  <= (irr & ~take) | rise;
            isr  <= (isr & ~drop) | (aeoi ? '0 : take);
        end
    end

    // R12: a spurious acknowledge never adds an in-service bit
    p_spurious_no_isr_r12: assert property (@(posedge clk) disable iff (rst)
        (ack && !grant) |=> ((isr & ~$past(isr)) == '0));

    // R5: with auto-EOI an acknowledge never adds an in-service bit
    p_aeoi_no_isr_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && grant && aeoi) |=> ((isr & ~$past(isr)) == '0));

    // R9: a real acknowledge records the level
    p_ack_sets_isr_r9: assert property (@(posedge clk) disable iff (rst)
        (ack && grant && !aeoi) |=> isr[$past(grant_lvl)]);

    // R10: a specific EOI retires its level unless re-entered in the same cycle
    p_eoi_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !(ack && grant && !aeoi && grant_lvl == eoi_lvl)) |=> !isr[$past(eoi_lvl)]);

    // R8: an acknowledged request is consumed unless a fresh edge arrives
    p_ack_clears_irr_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && grant && !rise[grant_lvl]) |=> !irr[$past(grant_lvl)]);

endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve
    import pic8_pkg::*;
(
    input  logic [LINES-1:0] irr,
    input  logic [LINES-1:0] isr,
    input  logic [LINES-1:0] mask,
    input  logic             ready,
    input  logic [DW-1:0]    base,
    output logic             int_out,
    output logic [LW-1:0]    grant_lvl,
    output logic [DW-1:0]    vector
);

    logic [LINES-1:0] cand;
    logic [LW-1:0]    best, busy_top;
    logic             beats_busy;

    assign cand       = irr & ~mask;
    assign best       = first_set(cand);
    assign busy_top   = first_set(isr);
    assign beats_busy = (isr == '0) || (best < busy_top);
    assign int_out    = ready && (cand != '0) && beats_busy;
    assign grant_lvl  = int_out ? best : LW'(LINES - 1);
    assign vector     = base + DW'(grant_lvl);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          slave_mode,
    input  logic [7:0]    irq_in,
    input  logic          int_ack,
    output logic          int_out,
    output logic [7:0]    int_vector,
    output logic [7:0]    cascade_cfg
);

    pic_cfg_t         cfg;
    logic             ready, rd_isr, eoi_valid;
    logic [LW-1:0]    eoi_lvl, grant_lvl;
    logic [LINES-1:0] mask, irr, isr;

    pic8_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .slave_mode(slave_mode), .cfg(cfg), .ready(ready), .mask(mask),
        .rd_isr(rd_isr), .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl)
    );

    pic8_pending u_pend (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack(int_ack), .grant(int_out),
        .grant_lvl(grant_lvl), .aeoi(cfg.aeoi), .eoi_valid(eoi_valid),
        .eoi_lvl(eoi_lvl), .irr(irr), .isr(isr)
    );

    pic8_resolve u_res (
        .irr(irr), .isr(isr), .mask(mask), .ready(ready), .base(cfg.base),
        .int_out(int_out), .grant_lvl(grant_lvl), .vector(int_vector)
    );

    assign bus_rdata   = bus_addr ? mask : (rd_isr ? isr : irr);
    assign cascade_cfg = cfg.casc;

    // R2: silent while not fully initialized
    p_quiet_uninit_r2: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !int_out);

    // R7: a forwarded level is never a masked one
    p_unmasked_grant_r7: assert property (@(posedge clk) disable iff (rst)
        int_out |-> !mask[grant_lvl]);

    // R12: a spurious acknowledge presents base+7
    p_spurious_vec_r12: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_out) |-> (int_vector == cfg.base + 8'd7));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       slave_mode = 1'b0;
    logic [7:0] irq_in = 8'h00;
    logic       int_ack = 1'b0;
    logic       int_out;
    logic [7:0] int_vector;
    logic [7:0] cascade_cfg;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slave_mode(slave_mode),
        .irq_in(irq_in), .int_ack(int_ack), .int_out(int_out),
        .int_vector(int_vector), .cascade_cfg(cascade_cfg)
    );

    // rows: {mask, pulsed lines, expect int_out (4b), expected level (4b)}
    localparam logic [23:0] VEC [0:5] = '{
        24'h00_01_10,  // R7 single line 0
        24'h00_0C_12,  // R7 line 2 beats line 3
        24'h04_0C_13,  // R6 line 2 masked, line 3 wins
        24'hFF_10_07,  // R12 all masked: spurious
        24'h00_80_17,  // R7 lowest line alone
        24'hF0_F0_07   // R12 masked group: spurious
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        irq_in = 8'h00;
        int_ack = 1'b0;
        bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] lines);
        @(negedge clk);
        irq_in = irq_in | lines;
        @(negedge clk);
        irq_in = irq_in & ~lines;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        int_ack = 1'b1;
        #1;
        v = int_vector;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic do_init(input logic [7:0] base, input logic [7:0] w3, input logic [7:0] w4);
        wr(1'b0, 8'h11);
        wr(1'b1, base);
        wr(1'b1, w3);
        wr(1'b1, w4);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r, v;

        // R1: reset state
        do_reset();
        check(int_out == 1'b0, "R1 int_out", int_out, 0);
        rd(1'b0, r); check(r == 8'h00, "R1 request reg", r, 8'h00);
        rd(1'b1, r); check(r == 8'h00, "R1 mask reg", r, 8'h00);

        // table-driven main function
        foreach (VEC[i]) begin
            logic [7:0] m, p, lvl;
            logic       e;
            m = VEC[i][23:16];
            p = VEC[i][15:8];
            e = VEC[i][4];
            lvl = {4'h0, VEC[i][3:0]};
            do_reset();
            do_init(8'h20, 8'h04, 8'h01);
            wr(1'b1, m);
            pulse(p);
            check(int_out == e, "R7 table int_out", int_out, e);
            do_ack(v);
            check(v == 8'h20 + lvl, "R3 table vector", v, 8'h20 + lvl);
            wr(1'b0, 8'h0B);
            rd(1'b0, r);
            check(r == (e ? (8'h01 << lvl) : 8'h00), "R12 table in-service", r,
                  e ? (8'h01 << lvl) : 8'h00);
        end

        // R2/R8: requests before init latch but stay silent
        do_reset();
        pulse(8'h01);
        check(int_out == 1'b0, "R2 silent before init", int_out, 0);
        rd(1'b0, r); check(r == 8'h01, "R8 edge latched", r, 8'h01);
        wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04);
        check(int_out == 1'b0, "R2 silent before mode word", int_out, 0);
        wr(1'b1, 8'h01);
        check(int_out == 1'b1, "R2 active after init", int_out, 1);
        check(cascade_cfg == 8'h04, "R4 master map", cascade_cfg, 8'h04);

        do_ack(v);
        check(v == 8'h40, "R3 vector line0", v, 8'h40);
        rd(1'b0, r); check(r == 8'h00, "R8 ack clears request", r, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check(r == 8'h01, "R9 in-service set", r, 8'h01);

        // R7: lower level blocked by level 0 in service
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk);
        check(int_out == 1'b0, "R7 blocked by in-service", int_out, 0);
        wr(1'b0, 8'h60);
        rd(1'b0, r); check(r == 8'h00, "R10 eoi level0", r, 8'h00);
        check(int_out == 1'b1, "R7 unblocked after eoi", int_out, 1);
        do_ack(v);
        check(v == 8'h43, "R3 vector line3", v, 8'h43);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h0A);
        rd(1'b0, r); check(r == 8'h00, "R8 held level no re-request", r, 8'h00);
        pulse(8'h20);
        check(int_out == 1'b0, "R7 line5 below line3", int_out, 0);
        pulse(8'h02);
        check(int_out == 1'b1, "R7 line1 above line3", int_out, 1);
        do_ack(v);
        check(v == 8'h41, "R3 vector line1", v, 8'h41);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check(r == 8'h0A, "R9 nested in-service", r, 8'h0A);
        wr(1'b0, 8'h63);
        rd(1'b0, r); check(r == 8'h02, "R10 only level3 cleared", r, 8'h02);

        // R13: acknowledge and specific EOI in one cycle
        pulse(8'h01);
        @(negedge clk);
        int_ack = 1'b1;
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h61;
        #1; v = int_vector;
        @(negedge clk);
        int_ack = 1'b0; bus_wr = 1'b0;
        check(v == 8'h40, "R13 vector during overlap", v, 8'h40);
        rd(1'b0, r); check(r == 8'h01, "R13 overlap in-service", r, 8'h01);
        irq_in[3] = 1'b0;

        // R11: read selection
        wr(1'b0, 8'h0A);
        rd(1'b0, r); check(r == 8'h20, "R11 request view", r, 8'h20);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check(r == 8'h01, "R11 in-service view", r, 8'h01);

        // R6: masking
        wr(1'b1, 8'hFF);
        rd(1'b1, r); check(r == 8'hFF, "R6 mask readback", r, 8'hFF);
        wr(1'b0, 8'h60);
        check(int_out == 1'b0, "R6 all masked", int_out, 0);
        wr(1'b1, 8'hDF);
        check(int_out == 1'b1, "R6 line5 unmasked", int_out, 1);

        // R4/R5: downstream controller with auto-EOI
        do_reset();
        slave_mode = 1'b1;
        do_init(8'h08, 8'hFA, 8'h02);
        check(cascade_cfg == 8'h02, "R4 slave identity", cascade_cfg, 8'h02);
        pulse(8'h10);
        do_ack(v);
        check(v == 8'h0C, "R3 slave vector", v, 8'h0C);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check(r == 8'h00, "R5 auto-eoi no in-service", r, 8'h00);
        slave_mode = 1'b0;

        // R2: sequence without mode word
        do_reset();
        pulse(8'h40);
        wr(1'b0, 8'h10); wr(1'b1, 8'h50);
        check(int_out == 1'b0, "R2 mid-sequence silent", int_out, 0);
        wr(1'b1, 8'h00);
        check(int_out == 1'b1, "R2 ready without mode word", int_out, 1);
        do_ack(v);
        check(v == 8'h56, "R3 vector line6", v, 8'h56);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule